// File: doc/BRIEF.md
# Preload Register Coherence Unit

This block lets a compiler hoist a load, and the instructions that use its result, above stores that might write the same memory. When such a speculative load (a preload) issues, the unit records its address, access size and destination general register in one of a few address slots, and marks the register as under coherence. Each later store is compared at the same time against every live slot. Where a store's bytes overlap a preloaded range, the unit tells the register file to merge the overlapping store bytes into the preloaded register. The register then holds the value a load issued after the store would have returned.

Tracking ends when the register is first read. When all slots are busy, a new preload takes a slot from an older one in round-robin order. The register that loses its slot is marked frozen. Its first later read raises a reload request carrying the address and size kept for it, so the pipeline can fetch the value again from memory. Every port is a plain valid-qualified strobe with no back-pressure: the unit accepts a preload, a store and a use together in any cycle. Its write-merge and reload outputs are valid in that same cycle and must be acted on there.

Top module: `preload_coherence_unit`

## Requirements
- R1: After reset no slot is live and no register is preloaded or frozen, so stores produce no merge and uses produce no reload.
- R2: A preload takes the lowest-numbered free slot. The slot number is the bit position in `wr_hit` that a later matching store reports.
- R3: Size code 0, 1 and 2 mean 1, 2 and 4 bytes. The low address bits below the size are ignored (natural alignment). The byte lanes covered are counted from the low address bits within the 32-bit word.
- R4: When a store's byte lanes overlap a live slot in the same word, the unit raises `wr_hit` for that slot in the store's own cycle. In that cycle it drives the slot's register on its `wr_reg` field and the overlapping lanes on its `wr_mask` field, and `wr_data` equals `st_data`. A preload arriving in the same cycle as the store is younger and is not compared.
- R5: All live slots are compared in parallel, and each overlapping slot reports its own hit in the same cycle.
- R6: A store to a different word, or to disjoint lanes of the same word, reports no hit.
- R7: Reading a preloaded register ends its tracking: its slot is freed and later stores to that address produce no merge.
- R8: A preload that finds no free slot evicts the slot at a round-robin pointer, which starts at 0 and advances only on an eviction. The evicted slot's register becomes frozen.
- R9: Reading a frozen register raises `rl_valid` in that cycle, with the address and size of its last preload, and clears the frozen mark, so a second read raises nothing.
- R10: A preload to a register that is already tracked first frees that register's old slot, so no register is ever linked to two slots.
- R11: When a use and a preload name the same register in one cycle, the use is applied first (ending tracking, or reloading if the register is frozen), and then the new preload is tracked.
- R12: A new preload to a frozen register clears its frozen mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pl_valid | input | 1 | Preload issues this cycle |
| pl_reg | input | 4 | Preload destination register |
| pl_addr | input | 16 | Preload byte address |
| pl_size | input | 2 | Preload size code |
| st_valid | input | 1 | Store completes this cycle |
| st_addr | input | 16 | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | 32 | Store data, lane-aligned in the word |
| use_valid | input | 1 | A register is read this cycle |
| use_reg | input | 4 | Register being read |
| wr_hit | output | 4 | Per-slot merge strobe |
| wr_reg | output | 16 | Per-slot target register, 4 bits each |
| wr_mask | output | 16 | Per-slot lane mask, 4 bits each |
| wr_data | output | 32 | Data to merge under the masks |
| rl_valid | output | 1 | Reload the register being used |
| rl_addr | output | 16 | Address to reload from |
| rl_size | output | 2 | Size of the reload |

## Verification
The bench goes after lane overlap at the edges: a byte store next to a byte preload in the same word, and a half-word that overlaps only part of a word preload. A design that compared words without comparing lanes would merge into the wrong register there. It fills the table and evicts twice in a row, then checks which registers reload and with which address. A pointer that also moved on ordinary allocations would freeze the wrong register. It also checks re-preload of a tracked register and use-and-preload of one register in the same cycle. A design that linked one register to two slots would keep merging stale addresses, and one that applied the preload before the use would drop the new tracking at once.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int SIZE_W    = 2;
  localparam int MAX_BYTES = 64;

  // Lanes covered by a naturally aligned access of 2**sz bytes at lane offset
  function automatic logic [MAX_BYTES-1:0] lane_mask(input int lane, input int sz);
    logic [MAX_BYTES-1:0] m;
    int n;
    int base;
    n    = 1 << sz;
    base = (lane / n) * n;
    for (int b = 0; b < MAX_BYTES; b++) m[b] = (b >= base) && (b < base + n);
    return m;
  endfunction
endpackage

// File: rtl/pcu_store_match.sv
module pcu_store_match
  import pcu_pkg::*;
#(
  parameter int NUM_AREG = 4,
  parameter int ADDR_W   = 16,
  parameter int BYTES    = 4,
  parameter int LANE_W   = 2
) (
  input  logic                    st_valid,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [SIZE_W-1:0]       st_size,
  input  logic [NUM_AREG-1:0]     ent_v,
  input  logic [ADDR_W-1:0]       ent_addr [NUM_AREG],
  input  logic [SIZE_W-1:0]       ent_size [NUM_AREG],
  output logic [NUM_AREG-1:0]     hit,
  output logic [NUM_AREG*BYTES-1:0] mask
);
  logic [MAX_BYTES-1:0] st_full;
  logic [BYTES-1:0]     st_lanes;

  assign st_full  = lane_mask(int'(st_addr[LANE_W-1:0]), int'(st_size));
  assign st_lanes = st_full[BYTES-1:0];

  for (genvar i = 0; i < NUM_AREG; i++) begin : g_slot
    logic [MAX_BYTES-1:0] e_full;
    logic [BYTES-1:0]     overlap;
    logic                 same_word;
    assign e_full    = lane_mask(int'(ent_addr[i][LANE_W-1:0]), int'(ent_size[i]));
    assign same_word = ent_addr[i][ADDR_W-1:LANE_W] == st_addr[ADDR_W-1:LANE_W];
    assign overlap   = (st_valid && ent_v[i] && same_word) ? (e_full[BYTES-1:0] & st_lanes) : '0;
    assign mask[i*BYTES +: BYTES] = overlap;
    assign hit[i] = |overlap;
  end
endmodule

// File: rtl/pcu_alloc.sv
module pcu_alloc #(
  parameter int NUM_AREG = 4,
  parameter int AIDX_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic [NUM_AREG-1:0] free_vec,
  output logic [AIDX_W-1:0]   slot,
  output logic                evict
);
  logic [AIDX_W-1:0] rr_q;
  logic [AIDX_W-1:0] pick;
  logic              any_free;

  always_comb begin
    any_free = 1'b0;
    pick     = '0;
    for (int i = NUM_AREG - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        any_free = 1'b1;
        pick     = AIDX_W'(i);
      end
    end
  end

  assign evict = req && !any_free;
  assign slot  = any_free ? pick : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rr_q <= '0;
    else if (evict) rr_q <= (rr_q == AIDX_W'(NUM_AREG - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/preload_coherence_unit.sv
module preload_coherence_unit
  import pcu_pkg::*;
#(
  parameter int NUM_AREG = 4,
  parameter int NUM_GREG = 16,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  localparam int BYTES   = DATA_W / 8,
  localparam int LANE_W  = $clog2(BYTES),
  localparam int AIDX_W  = $clog2(NUM_AREG),
  localparam int GIDX_W  = $clog2(NUM_GREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pl_valid,
  input  logic [GIDX_W-1:0]          pl_reg,
  input  logic [ADDR_W-1:0]          pl_addr,
  input  logic [SIZE_W-1:0]          pl_size,
  input  logic                       st_valid,
  input  logic [ADDR_W-1:0]          st_addr,
  input  logic [SIZE_W-1:0]          st_size,
  input  logic [DATA_W-1:0]          st_data,
  input  logic                       use_valid,
  input  logic [GIDX_W-1:0]          use_reg,
  output logic [NUM_AREG-1:0]        wr_hit,
  output logic [NUM_AREG*GIDX_W-1:0] wr_reg,
  output logic [NUM_AREG*BYTES-1:0]  wr_mask,
  output logic [DATA_W-1:0]          wr_data,
  output logic                       rl_valid,
  output logic [ADDR_W-1:0]          rl_addr,
  output logic [SIZE_W-1:0]          rl_size
);
  // Address slots
  logic [NUM_AREG-1:0] ent_v;
  logic [ADDR_W-1:0]   ent_addr [NUM_AREG];
  logic [SIZE_W-1:0]   ent_size [NUM_AREG];
  logic [GIDX_W-1:0]   ent_reg  [NUM_AREG];
  // Per-register state
  logic [NUM_GREG-1:0] greg_p;
  logic [NUM_GREG-1:0] greg_f;
  logic [AIDX_W-1:0]   greg_link [NUM_GREG];
  logic [ADDR_W-1:0]   greg_addr [NUM_GREG];
  logic [SIZE_W-1:0]   greg_size [NUM_GREG];

  logic [NUM_AREG-1:0] ent_v_mid;
  logic [AIDX_W-1:0]   slot;
  logic                evict;
  logic [GIDX_W-1:0]   victim_reg;

  pcu_store_match #(
    .NUM_AREG(NUM_AREG), .ADDR_W(ADDR_W), .BYTES(BYTES), .LANE_W(LANE_W)
  ) match_i (
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .ent_v(ent_v), .ent_addr(ent_addr), .ent_size(ent_size),
    .hit(wr_hit), .mask(wr_mask)
  );

  for (genvar i = 0; i < NUM_AREG; i++) begin : g_wreg
    assign wr_reg[i*GIDX_W +: GIDX_W] = ent_reg[i];
  end
  assign wr_data = st_data;

  // Use is applied before the allocation; re-preload frees the old slot
  always_comb begin
    ent_v_mid = ent_v;
    if (use_valid && greg_p[use_reg]) ent_v_mid[greg_link[use_reg]] = 1'b0;
    if (pl_valid && greg_p[pl_reg])   ent_v_mid[greg_link[pl_reg]]  = 1'b0;
  end

  pcu_alloc #(.NUM_AREG(NUM_AREG), .AIDX_W(AIDX_W)) alloc_i (
    .clk(clk), .rst_n(rst_n), .req(pl_valid), .free_vec(~ent_v_mid),
    .slot(slot), .evict(evict)
  );

  assign victim_reg = ent_reg[slot];

  assign rl_valid = use_valid && greg_f[use_reg];
  assign rl_addr  = greg_addr[use_reg];
  assign rl_size  = greg_size[use_reg];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v  <= '0;
      greg_p <= '0;
      greg_f <= '0;
    end else begin
      ent_v <= ent_v_mid;
      if (pl_valid) ent_v[slot] <= 1'b1;
      if (use_valid) begin
        greg_p[use_reg] <= 1'b0;
        greg_f[use_reg] <= 1'b0;
      end
      if (evict) begin
        greg_p[victim_reg] <= 1'b0;
        greg_f[victim_reg] <= 1'b1;
      end
      if (pl_valid) begin
        greg_p[pl_reg] <= 1'b1;
        greg_f[pl_reg] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pl_valid) begin
      ent_addr[slot]    <= pl_addr;
      ent_size[slot]    <= pl_size;
      ent_reg[slot]     <= pl_reg;
      greg_link[pl_reg] <= slot;
      greg_addr[pl_reg] <= pl_addr;
      greg_size[pl_reg] <= pl_size;
    end
  end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int NUM_AREG = 4,
  parameter int GIDX_W   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pl_valid,
  input logic [GIDX_W-1:0]   pl_reg,
  input logic                st_valid,
  input logic                use_valid,
  input logic [GIDX_W-1:0]   use_reg,
  input logic [NUM_AREG-1:0] wr_hit,
  input logic                rl_valid,
  input logic [NUM_AREG-1:0] ent_v
);
  // R9: a reload request only ever answers a register read
  assert_reload_needs_use_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rl_valid |-> use_valid);

  // R4: merges come only from a store in the same cycle
  assert_merge_needs_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_hit) |-> st_valid);

  // R9: a read clears the frozen mark, so reading again cannot reload
  assert_no_repeat_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (use_valid && !(pl_valid && pl_reg == use_reg))
      |=> !(use_valid && rl_valid && use_reg == $past(use_reg)));

  // R2: a preload always leaves at least one live slot behind it
  assert_preload_tracked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |=> (ent_v != '0));
endmodule

bind preload_coherence_unit pcu_checker #(.NUM_AREG(NUM_AREG), .GIDX_W(GIDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pl_valid(pl_valid), .pl_reg(pl_reg),
  .st_valid(st_valid), .use_valid(use_valid), .use_reg(use_reg),
  .wr_hit(wr_hit), .rl_valid(rl_valid), .ent_v(ent_v)
);

// File: tb/preload_coherence_unit_tb_top.sv
module preload_coherence_unit_tb_top;
  localparam int NA = 4;
  localparam int NG = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        pl_valid = 0, st_valid = 0, use_valid = 0;
  logic [3:0]  pl_reg = 0, use_reg = 0;
  logic [15:0] pl_addr = 0, st_addr = 0;
  logic [1:0]  pl_size = 0, st_size = 0;
  logic [31:0] st_data = 0;
  logic [NA-1:0]   wr_hit;
  logic [NA*4-1:0] wr_reg, wr_mask;
  logic [31:0] wr_data;
  logic        rl_valid;
  logic [15:0] rl_addr;
  logic [1:0]  rl_size;

  preload_coherence_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .pl_valid(pl_valid), .pl_reg(pl_reg), .pl_addr(pl_addr), .pl_size(pl_size),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
    .use_valid(use_valid), .use_reg(use_reg),
    .wr_hit(wr_hit), .wr_reg(wr_reg), .wr_mask(wr_mask), .wr_data(wr_data),
    .rl_valid(rl_valid), .rl_addr(rl_addr), .rl_size(rl_size)
  );

  // Reference model state
  bit          m_v [NA];
  logic [15:0] m_addr [NA];
  logic [1:0]  m_size [NA];
  int          m_reg [NA];
  bit          m_p [NG];
  bit          m_f [NG];
  int          m_link [NG];
  logic [15:0] m_gaddr [NG];
  logic [1:0]  m_gsize [NG];
  int          m_rr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  function automatic logic [3:0] lanes(logic [15:0] a, logic [1:0] s);
    case (s)
      2'd0:    return 4'b0001 << a[1:0];
      2'd1:    return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic model_update(bit pv, int pr, logic [15:0] pa, logic [1:0] ps, bit uv, int ur);
    int slot;
    slot = -1;
    if (uv) begin
      if (m_p[ur]) m_v[m_link[ur]] = 0;
      m_p[ur] = 0;
      m_f[ur] = 0;
    end
    if (pv) begin
      if (m_p[pr]) m_v[m_link[pr]] = 0;
      for (int i = NA - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr;
        m_p[m_reg[slot]] = 0;
        m_f[m_reg[slot]] = 1;
        m_rr = (m_rr + 1) % NA;
      end
      m_v[slot] = 1; m_addr[slot] = pa; m_size[slot] = ps; m_reg[slot] = pr;
      m_p[pr] = 1; m_f[pr] = 0; m_link[pr] = slot; m_gaddr[pr] = pa; m_gsize[pr] = ps;
    end
  endtask

  task automatic step(string tag, bit pv, int pr, logic [15:0] pa, logic [1:0] ps,
                      bit sv, logic [15:0] sa, logic [1:0] ss, logic [31:0] sd,
                      bit uv, int ur);
    logic [NA-1:0] eh;
    logic [3:0]    em [NA];
    bit            erl;
    bit            bad;
    @(negedge clk);
    pl_valid = pv; pl_reg = pr[3:0]; pl_addr = pa; pl_size = ps;
    st_valid = sv; st_addr = sa; st_size = ss; st_data = sd;
    use_valid = uv; use_reg = ur[3:0];
    #3;
    bad = 0;
    for (int i = 0; i < NA; i++) begin
      em[i] = '0;
      if (sv && m_v[i] && m_addr[i][15:2] == sa[15:2]) em[i] = lanes(m_addr[i], m_size[i]) & lanes(sa, ss);
      eh[i] = |em[i];
      if (wr_hit[i] !== eh[i]) bad = 1;
      if (eh[i] && (wr_mask[i*4 +: 4] !== em[i] || wr_reg[i*4 +: 4] !== 4'(m_reg[i]))) bad = 1;
    end
    if (sv && wr_data !== sd) bad = 1;
    erl = uv && m_f[ur];
    if (rl_valid !== erl) bad = 1;
    if (erl && (rl_addr !== m_gaddr[ur] || rl_size !== m_gsize[ur])) bad = 1;
    checks++;
    if (bad) begin
      failures++;
      $display("FAIL %s: hit=%b mask=%h reg=%h rl=%b/%h/%0d exp hit=%b mask=%h%h%h%h rl=%b/%h/%0d",
               tag, wr_hit, wr_mask, wr_reg, rl_valid, rl_addr, rl_size,
               eh, em[3], em[2], em[1], em[0], erl, erl ? m_gaddr[ur] : 16'h0, erl ? m_gsize[ur] : 2'd0);
    end
    @(posedge clk);
    model_update(pv, pr, pa, ps, uv, ur);
  endtask

  task automatic pre(string t, int r, logic [15:0] a, logic [1:0] s);
    step(t, 1, r, a, s, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic sto(string t, logic [15:0] a, logic [1:0] s);
    step(t, 0, 0, 0, 0, 1, a, s, $urandom, 0, 0);
  endtask
  task automatic rd(string t, int r);
    step(t, 0, 0, 0, 0, 0, 0, 0, 0, 1, r);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog: expired, expected run to finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < NA; i++) m_v[i] = 0;
    for (int i = 0; i < NG; i++) begin m_p[i] = 0; m_f[i] = 0; end
    m_rr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: empty after reset
    sto("R1", 16'h0010, 2);
    rd("R1", 3);
    // R2, R3, R4, R6
    pre("R2", 1, 16'h0100, 2);
    pre("R2", 2, 16'h0200, 0);
    sto("R4", 16'h0100, 2);
    sto("R6", 16'h0201, 0);
    sto("R3", 16'h0201, 1);
    sto("R6", 16'h0300, 2);
    // R4: preload in the same cycle as a matching store is not compared
    step("R4", 1, 3, 16'h0102, 1, 1, 16'h0102, 0, 32'hA5A5A5A5, 0, 0);
    // R5: two slots hit together
    sto("R5", 16'h0100, 2);
    // R7: use ends tracking
    rd("R7", 1);
    sto("R7", 16'h0100, 0);
    // R10: re-preload frees old slot
    pre("R10", 3, 16'h0400, 2);
    sto("R10", 16'h0102, 1);
    sto("R10", 16'h0400, 2);
    // R8: fill and evict twice
    pre("R8", 4, 16'h0500, 2);
    pre("R8", 5, 16'h0600, 2);
    pre("R8", 6, 16'h0700, 1);
    sto("R8", 16'h0702, 1);
    pre("R8", 7, 16'h0800, 2);
    sto("R8", 16'h0200, 0);
    // R9: reloads of frozen registers
    rd("R9", 3);
    rd("R9", 3);
    rd("R9", 2);
    // R12: preload of a frozen register clears the mark
    pre("R12", 8, 16'h0900, 2);
    pre("R12", 9, 16'h0A00, 2);
    pre("R12", 4, 16'h0B00, 0);
    rd("R12", 4);
    rd("R12", 5);
    // R11: use and preload of one register together
    step("R11", 1, 6, 16'h0C00, 2, 0, 0, 0, 0, 1, 6);
    sto("R11", 16'h0700, 2);
    sto("R11", 16'h0C00, 2);
    pre("R11", 10, 16'h0D00, 2);
    pre("R11", 11, 16'h0E00, 2);
    step("R11", 1, 8, 16'h0F00, 0, 0, 0, 0, 0, 1, 8);
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 1, 9);

    // Random mix against the model
    for (int n = 0; n < 4000; n++) begin
      step("R5 random", ($urandom % 3) == 0, $urandom % 8, 16'($urandom % 64), 2'($urandom % 3),
           ($urandom % 2) == 0, 16'($urandom % 64), 2'($urandom % 3), $urandom,
           ($urandom % 3) == 0, $urandom % 8);
    end
    finish_run();
  end
endmodule